// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits between two independent ports of a shared memory and watches, on every clock, the address and active-low select of each port. When both ports are selected and point at the same location, it chooses one port to keep access and flags the other as busy with an active-low busy output. It also raises a write-block signal for the losing port. The memory uses that signal to drop the losing port's write, whatever level the external busy line shows.

The choice follows order of arrival. A port "arrives" on the cycle its select goes low, or on a cycle where its address changes while it is selected. When the two ports collide, the port that arrived earlier wins. If both arrive in the same cycle, the left port wins by fixed priority. The decision is latched and held until the collision ends: the addresses differ, or either select goes high. Only then are both busy flags released. All outputs are registered, so they reflect the inputs sampled at the previous rising clock edge.

Top module: `abm_arbiter`

## Requirements
- R1: If either select input is high, or the two addresses differ, then after the next rising edge both busy outputs are high and both write-block outputs are low.
- R2: If both selects are low and the addresses are equal, then after the next rising edge exactly one busy output is low.
- R3: A port arrives in a cycle where its select is low and either its select was high in the previous cycle or its address differs from the previous cycle. When a collision starts, the port that arrives in that cycle is made busy if the other port did not arrive in the same cycle.
- R4: When both ports arrive in the cycle a collision starts, the right port is made busy (`r_busy_n` = 0) and the left port keeps access.
- R5: `l_busy_n` and `r_busy_n` are never both low.
- R6: `l_wr_block` is 1 exactly when `l_busy_n` is 0, and `r_wr_block` is 1 exactly when `r_busy_n` is 0, in every cycle.
- R7: While the collision persists, the latched winner is kept, even if both ports move together to a new equal address in the same cycle.
- R8: After synchronous reset (`rst` = 1 at a rising edge), both busy outputs are high, both write-block outputs are low, and no winner is held. The next collision is decided by arrival order alone.
- R9: One cycle after a collision ends, both busy outputs are high. A later collision is arbitrated afresh and may pick the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| l_addr | input | AW (11) | Left port address |
| l_sel_n | input | 1 | Left port select, active low |
| r_addr | input | AW (11) | Right port address |
| r_sel_n | input | 1 | Right port select, active low |
| l_busy_n | output | 1 | Left busy flag, active low, registered |
| r_busy_n | output | 1 | Right busy flag, active low, registered |
| l_wr_block | output | 1 | Internal write inhibit for the left port |
| r_wr_block | output | 1 | Internal write inhibit for the right port |

## Verification
The hardest situation to reach from the ports is an ongoing collision in which the losing port re-arrives. To do this, both ports must move to a new shared address in the same cycle, so the match never breaks and the latch, not arrival order, must decide. The bench uses a narrow two-bit address so that matches are frequent. It walks through every ordered pair of full input states back to back, which creates same-cycle arrivals, one-sided arrivals and collisions that persist across address moves. A directed sequence then covers reset, release and re-arbitration in the other direction.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;

  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;
endpackage

// File: rtl/abm_arrival.sv
module abm_arrival #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          sel_n,
  output logic          arrive
);
  logic [AW-1:0] addr_q;
  logic          en_q;
  logic          en;

  assign en = ~sel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      en_q   <= en;
    end
  end

  assign arrive = en && (!en_q || (addr != addr_q));

  // R3: a port that has just dropped its select has arrived
  p_sel_edge_arrives_r3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && $past(sel_n)) |-> arrive);
endmodule

// File: rtl/abm_decide.sv
module abm_decide
  import abm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic arr_l,
  input  logic arr_r,
  output logic l_busy_n,
  output logic r_busy_n,
  output logic l_wr_block,
  output logic r_wr_block
);
  win_e win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (!match)                  win_d = WIN_NONE;
    else if (win_q == WIN_NONE) begin
      if (arr_l && !arr_r)       win_d = WIN_RIGHT;
      else                       win_d = WIN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= WIN_NONE;
      l_busy_n   <= 1'b1;
      r_busy_n   <= 1'b1;
      l_wr_block <= 1'b0;
      r_wr_block <= 1'b0;
    end else begin
      win_q      <= win_d;
      l_busy_n   <= (win_d != WIN_RIGHT);
      r_busy_n   <= (win_d != WIN_LEFT);
      l_wr_block <= (win_d == WIN_RIGHT);
      r_wr_block <= (win_d == WIN_LEFT);
    end
  end

  // R7: a held winner stays while the collision lasts
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (match && win_q != WIN_NONE) |=> (win_q == $past(win_q)));
  // R4: a same-cycle arrival on a fresh collision blocks the right port
  p_tie_left_r4: assert property (@(posedge clk) disable iff (rst)
    (match && win_q == WIN_NONE && arr_l && arr_r) |=> (!r_busy_n && l_busy_n));
  // R3: a lone late arrival loses
  p_late_left_r3: assert property (@(posedge clk) disable iff (rst)
    (match && win_q == WIN_NONE && arr_l && !arr_r) |=> !l_busy_n);
endmodule

// File: rtl/abm_arbiter.sv
module abm_arbiter
  import abm_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] l_addr,
  input  logic          l_sel_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_sel_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_block,
  output logic          r_wr_block
);
  logic [AW-1:0] addr_v [NPORT];
  logic          sel_v  [NPORT];
  logic          arr_v  [NPORT];
  logic          match;

  assign addr_v[PL] = l_addr;
  assign addr_v[PR] = r_addr;
  assign sel_v[PL]  = l_sel_n;
  assign sel_v[PR]  = r_sel_n;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    abm_arrival #(.AW(AW)) u_arr (
      .clk(clk), .rst(rst), .addr(addr_v[p]), .sel_n(sel_v[p]), .arrive(arr_v[p])
    );
  end

  assign match = !l_sel_n && !r_sel_n && (l_addr == r_addr);

  abm_decide u_dec (
    .clk(clk), .rst(rst), .match(match),
    .arr_l(arr_v[PL]), .arr_r(arr_v[PR]),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_block(l_wr_block), .r_wr_block(r_wr_block)
  );

  // R5
  p_never_both_r5: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n));
  // R1
  p_release_r1: assert property (@(posedge clk) disable iff (rst)
    (l_sel_n || r_sel_n || (l_addr != r_addr)) |=> (l_busy_n && r_busy_n));
  // R2
  p_one_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!l_sel_n && !r_sel_n && (l_addr == r_addr)) |=> (l_busy_n != r_busy_n));
  // R6
  p_block_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (l_wr_block == !l_busy_n) && (r_wr_block == !r_busy_n));
endmodule

// File: tb/abm_arbiter_test.sv
module abm_arbiter_test;
  localparam int AW = 2;
  localparam int NA = 1 << AW;

  logic clk = 0, rst = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_sel_n = 1, r_sel_n = 1;
  logic l_busy_n, r_busy_n, l_wr_block, r_wr_block;

  int total = 0, bad = 0;

  // bench reference state
  logic [AW-1:0] pa_l, pa_r;
  logic pe_l, pe_r;
  int   win;            // 0 none, 1 left kept, 2 right kept
  logic exp_l, exp_r;   // expected busy_n
  string tag;

  always #10 clk = ~clk;

  abm_arbiter #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .l_addr(l_addr), .l_sel_n(l_sel_n),
    .r_addr(r_addr), .r_sel_n(r_sel_n), .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_block(l_wr_block), .r_wr_block(r_wr_block)
  );

  task automatic chk(input string t, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s busy_n(l,r) act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic check_now();
    chk(tag, {l_busy_n, r_busy_n}, {exp_l, exp_r});
    chk("R6", {l_wr_block, r_wr_block}, {~l_busy_n, ~r_busy_n});
    chk("R5", {1'b0, (!l_busy_n && !r_busy_n)}, 2'b00);
  endtask

  // apply one input state at the negative edge and predict the outputs
  task automatic step(input logic [AW-1:0] al, input logic cl,
                      input logic [AW-1:0] ar, input logic cr);
    logic m, xl, xr;
    l_addr = al; l_sel_n = cl; r_addr = ar; r_sel_n = cr;
    m  = !cl && !cr && (al == ar);
    xl = !cl && (!pe_l || al != pa_l);
    xr = !cr && (!pe_r || ar != pa_r);
    if (!m) begin win = 0; tag = "R1"; end
    else if (win != 0) tag = "R7";
    else if (xl && xr) begin win = 1; tag = "R4"; end
    else if (xl) begin win = 2; tag = "R3"; end
    else begin win = 1; tag = "R3"; end
    exp_l = (win != 2);
    exp_r = (win != 1);
    pa_l = al; pe_l = !cl; pa_r = ar; pe_r = !cr;
    @(negedge clk);
    check_now();
    if (m) chk("R2", {1'b0, l_busy_n ^ r_busy_n}, 2'b01);
  endtask

  task automatic do_reset();
    rst = 1;
    l_sel_n = 1; r_sel_n = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    pa_l = '0; pa_r = '0; pe_l = 0; pe_r = 0; win = 0;
    exp_l = 1; exp_r = 1; tag = "R8";
    chk("R8", {l_busy_n, r_busy_n, l_wr_block, r_wr_block} >> 2, 2'b11);
    chk("R8", {l_wr_block, r_wr_block}, 2'b00);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R8: first collision after reset, right selects while left is held
    step(2'd1, 0, 2'd2, 1);
    step(2'd1, 0, 2'd1, 0);      // R3: right late -> right busy
    chk("R3", {l_busy_n, r_busy_n}, 2'b10);
    step(2'd1, 0, 2'd1, 0);      // held
    chk("R7", {l_busy_n, r_busy_n}, 2'b10);
    step(2'd3, 0, 2'd3, 0);      // both move together, winner kept
    chk("R7", {l_busy_n, r_busy_n}, 2'b10);
    step(2'd3, 1, 2'd3, 0);      // left deselects -> release
    chk("R9", {l_busy_n, r_busy_n}, 2'b11);
    step(2'd3, 0, 2'd3, 0);      // left arrives late now -> left busy
    chk("R9", {l_busy_n, r_busy_n}, 2'b01);
    step(2'd0, 0, 2'd3, 0);
    chk("R1", {l_busy_n, r_busy_n}, 2'b11);
    step(2'd2, 1, 2'd2, 1);
    step(2'd2, 0, 2'd2, 0);      // same-cycle arrival
    chk("R4", {l_busy_n, r_busy_n}, 2'b10);

    // exhaustive sweep of ordered pairs of input states
    for (int s0 = 0; s0 < NA * NA * 4; s0++) begin
      for (int s1 = 0; s1 < NA * NA * 4; s1++) begin
        step(AW'(s0 >> 2 >> AW), s0[1], AW'(s0 >> 2), s0[0]);
        step(AW'(s1 >> 2 >> AW), s1[1], AW'(s1 >> 2), s1[0]);
      end
    end

    do_reset();
    step(2'd2, 0, 2'd2, 0);
    chk("R8", {l_busy_n, r_busy_n}, 2'b10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule